// File: doc/BRIEF.md
# Signed Phase-Difference Time-to-Digital Converter

This block turns the phase offset between two square-wave oscillator outputs into a signed digital word. Both oscillators are locked to a common reference square wave, which the block itself produces by dividing its fast counting clock. During every high half of that reference, the block counts the counting-clock cycles in which the two synchronized oscillator signals disagree. It also records which oscillator rose first inside that half.

When the reference falls, the accumulated count is presented as an unsigned magnitude, together with a lead/lag sign bit, and a one-cycle valid strobe is raised. The accumulator and the lead/lag tracker then restart at the next rising edge of the reference. One least significant bit equals one counting-clock period. With the default parameter the reference period is 4096 counting-clock cycles, so each high half holds 2048 cycles and the magnitude is 11 bits wide.

Both oscillator inputs are asynchronous to the counting clock. Each passes through a two-flop synchronizer before any comparison is made.

Top module: `phase_tdc`

## Requirements
- R1: While reset is asserted (`rst_n` low), `mag`, `sign` and `valid` are all 0.
- R2: `mag` equals the number of counting-clock cycles, within one reference high half, in which the synchronized `osc_a` and `osc_b` differ. One LSB is one counting-clock period.
- R3: `sign` is 1 when `osc_a` rises before `osc_b` inside the reference high half.
- R4: `sign` is 0 when `osc_b` rises before `osc_a` inside the reference high half.
- R5: When both inputs rise in the same counting-clock cycle, the result is `sign` = 1 and `mag` = 0.
- R6: When the inputs differ for the whole high half (2048 cycles), `mag` saturates at 2047 instead of wrapping to 0.
- R7: `valid` is high for exactly one counting-clock cycle, once every 4096 cycles. `mag` and `sign` change only in the cycle in which `valid` rises.
- R8: Disagreement between the inputs during the reference low half adds nothing to `mag`.
- R9: If neither input rises inside the high half, `sign` is reported as 1, whatever the previous result was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast counting clock; the reference is derived from it |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_a | input | 1 | First oscillator output, asynchronous |
| osc_b | input | 1 | Second oscillator output, asynchronous |
| mag | output | 11 | Latched phase-difference magnitude in counting-clock cycles |
| sign | output | 1 | Latched lead/lag bit: 1 when `osc_a` leads |
| valid | output | 1 | One-cycle strobe marking a new `mag`/`sign` pair |

## Verification
The bench checks several windowing corners:
- An offset whose disagreement interval wraps from the end of one period into the start of the next. A design that scoped the count wrongly would report only part of the 200-cycle width.
- Inputs that disagree only in the low half. A design that ignored the gate would report a non-zero count.
- Rises that straddle the last cycles of the high half. An off-by-one here would move the count by one.

It also targets saturation at full width, where a wrapping counter would read 0. It drives a case with no rise in the window straight after a lagging result, which catches a stale sign bit. Finally, it exercises same-cycle rises and a one-cycle offset, which show whether sign priority and single-cycle resolution are correct.

// File: rtl/phase_tdc.sv
module phase_tdc #(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_a,
  input  logic             osc_b,
  output logic [CNT_W-2:0] mag,
  output logic             sign,
  output logic             valid
);
  localparam int MAG_W = CNT_W - 1;
  localparam logic [CNT_W-1:0] HALF    = CNT_W'(1) << (CNT_W - 1);
  localparam logic [MAG_W-1:0] MAG_MAX = '1;

  logic [CNT_W-1:0]     div_q;
  logic [SYNC_STAGES:0] a_pipe, b_pipe;
  logic [MAG_W-1:0]     acc;
  logic                 decided, lead;

  wire ref_hi = ~div_q[CNT_W-1];
  wire a_s    = a_pipe[SYNC_STAGES-1];
  wire b_s    = b_pipe[SYNC_STAGES-1];
  wire a_rise = a_s & ~a_pipe[SYNC_STAGES];
  wire b_rise = b_s & ~b_pipe[SYNC_STAGES];
  wire win    = ref_hi & (a_s ^ b_s);
  wire fall   = (div_q == HALF);
  wire wrap   = &div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      a_pipe <= '0;
      b_pipe <= '0;
    end else begin
      div_q  <= div_q + 1'b1;
      a_pipe <= {a_pipe[SYNC_STAGES-1:0], osc_a};
      b_pipe <= {b_pipe[SYNC_STAGES-1:0], osc_b};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || wrap) begin
      acc     <= '0;
      decided <= 1'b0;
      lead    <= 1'b1;
    end else begin
      if (win && acc != MAG_MAX) acc <= acc + 1'b1;
      if (ref_hi && !decided && (a_rise || b_rise)) begin
        decided <= 1'b1;
        lead    <= a_rise;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mag   <= '0;
      sign  <= 1'b0;
      valid <= 1'b0;
    end else begin
      valid <= fall;
      if (fall) begin
        mag  <= acc;
        sign <= lead;
      end
    end
  end
endmodule

module phase_tdc_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-2:0] mag,
  input logic             sign,
  input logic             valid
);
  localparam logic [CNT_W:0] PERIOD = (CNT_W+1)'(1) << CNT_W;

  logic [CNT_W:0] gap;
  logic           seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (valid) begin
      gap  <= 1;
      seen <= 1'b1;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  p_valid_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && seen) |-> gap == PERIOD);
  p_mag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> ($stable(mag) && $stable(sign)));
  p_zero_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && mag == '0) |-> sign);
endmodule

bind phase_tdc phase_tdc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mag(mag), .sign(sign), .valid(valid)
);

// File: tb/tb_phase_tdc.sv
module tb_phase_tdc;
  logic clk = 1'b0, rst_n = 1'b0, osc_a = 1'b0, osc_b = 1'b0;
  logic [10:0] mag;
  logic sign, valid;
  int tests = 0, fails = 0;
  int a_st = 0, a_w = 0, b_st = 0, b_w = 0;
  int tb_cyc = 0;

  phase_tdc dut (.clk(clk), .rst_n(rst_n), .osc_a(osc_a), .osc_b(osc_b),
                 .mag(mag), .sign(sign), .valid(valid));

  always #2.5 clk = ~clk;

  always @(posedge clk) tb_cyc <= rst_n ? tb_cyc + 1 : 0;

  function automatic logic on_at(int p, int st, int w);
    return (((p - st) % 4096 + 4096) % 4096) < w;
  endfunction

  always @(negedge clk) begin
    osc_a <= on_at(tb_cyc % 4096, a_st, a_w);
    osc_b <= on_at(tb_cyc % 4096, b_st, b_w);
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_valid(output int cycles);
    cycles = 0;
    do begin
      @(negedge clk);
      cycles++;
    end while (!valid && cycles < 10000);
    if (!valid) chk("watchdog", 0, 1);
  endtask

  task automatic run(string req, int as_, int aw, int bs, int bw, int em, int es);
    int c;
    a_st = as_; a_w = aw; b_st = bs; b_w = bw;
    wait_valid(c);
    wait_valid(c);
    chk({req, " mag"}, mag, em);
    chk({req, " sign"}, sign, es);
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    chk("R1 mag", mag, 0);
    chk("R1 sign", sign, 0);
    chk("R1 valid", valid, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_strobe();
    int c;
    wait_valid(c);
    @(negedge clk);
    chk("R7 strobe width", valid, 0);
    wait_valid(c);
    chk("R7 strobe period", c + 1, 4096);
  endtask

  initial begin
    t_reset();
    run("R5 R2 same-cycle rise", 100, 2048, 100, 2048, 0, 1);
    run("R2 R3 a leads 300", 100, 2048, 400, 2048, 300, 1);
    run("R4 b leads 777", 877, 2048, 100, 2048, 777, 0);
    run("R8 R9 low-half only", 2500, 100, 0, 0, 0, 1);
    run("R6 saturation", 0, 4096, 0, 0, 2047, 1);
    run("R2 R3 one cycle", 500, 2048, 501, 2048, 1, 1);
    run("R4 near window end", 2040, 2048, 2000, 2048, 40, 0);
    run("R2 R3 wrapping interval", 1900, 2048, 2100, 2048, 200, 1);
    t_strobe();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule